// File: doc/BRIEF.md
# LIN Bus Wake-up Pulse Detector

This block watches the LIN receive line while the controller is parked in wake-up mode and decides whether a dominant (low) pulse on the bus is a genuine wake-up request. It times the low phase in sample ticks. The tick period comes from a clock-source divider followed by a programmable power-of-two prescaler. A pulse counts as a wake-up once it has lasted 2.5 bit times, which is 40 ticks at 16 samples per bit. When that happens the block sets a sticky wake-up flag.

An 8-bit configuration register holds three fields. The first is a revision select, which can force the timing source to the undivided base clock whatever the normal clock-select input says. The second is a 3-bit prescaler exponent. The third is a 4-bit sampling-count code. The register can only be written while the controller is held in reset mode, and writes carrying a prohibited sampling code are discarded. The flag is cleared by a software strobe, but only once the bus has returned high.

Top module: `lin_wake_detect`

## Requirements
- R1: After reset the configuration register reads 0x00 and the wake-up flag is 0.
- R2: A configuration write takes effect only while `om_run_i` is 0 (reset mode). A write made while `om_run_i` is 1 leaves the register unchanged.
- R3: The sampling-count field is bits 7..4. It accepts only 4'b0000 or 4'b1111, both meaning 16 samples per bit. A write with any other code in bits 7..4 is dropped whole, and the previous register value is kept.
- R4: The prescaler field is bits 3..1 and holds a code p from 0 to 7. It divides the timing source by 2^p.
- R5: The revision select is bit 0. With bit 0 at 0, the timing source is the base clock divided by 2^`clk_sel_i`. With bit 0 at 1, the timing source is the undivided base clock whatever `clk_sel_i` holds. Either way, one sample tick lasts D = 2^(p + s) base-clock cycles, where s is `clk_sel_i` when bit 0 is 0 and 0 when bit 0 is 1.
- R6: A low phase of the synchronised receive line sets the flag once it has lasted 40 sample ticks. The measurement restarts on every falling edge, so a pulse shorter than 40·D cycles (less a few cycles of synchroniser slack) never sets the flag, even when several short pulses follow one another.
- R7: Measurement runs only while `wake_mode_i` and `om_run_i` are both 1. Otherwise no low pulse of any length sets the flag.
- R8: The flag stays set until `wake_clr_i` is pulsed while the synchronised bus is high. A clear strobe given while the bus is still low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | LIN receive line (asynchronous) |
| om_run_i | input | 1 | Operating-mode bit: 0 reset mode, 1 running |
| wake_mode_i | input | 1 | Controller is in wake-up mode |
| clk_sel_i | input | 2 | Normal clock-source select, divides the base clock by 2^value |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Current configuration register |
| wake_clr_i | input | 1 | Wake-up flag clear strobe |
| wake_o | output | 1 | Sticky wake-up flag |

## Verification
Some properties are checked by the assertions on every cycle. The register stays frozen while the controller runs or when a write carries a prohibited sampling code. The low-width counter never reaches the threshold value. A wake event never occurs outside wake-up mode or while the bus is high, and the flag rises only after such an event. The flag also holds through clear strobes given while the bus is low, and it drops after a clear given while the bus is high. Other behaviour can only be shown by the bench's scenarios. That covers the real tick period chosen by the prescaler, clock-select and revision bit, pulses just above and just below 40 ticks, and the restart of the count after a short pulse.

// File: rtl/lin_wk_pkg.sv
package lin_wk_pkg;

  localparam int unsigned CFG_W = 8;

  typedef struct packed {
    logic [3:0] spb_code;
    logic [2:0] pre_exp;
    logic       rev_fix;
  } wk_cfg_t;

  // Only two sampling codes are legal; both select 16 samples per bit.
  function automatic logic spb_code_ok(input logic [3:0] code);
    return (code == 4'h0) || (code == 4'hF);
  endfunction

  // Threshold in sample ticks for a length given in half-bit units.
  function automatic int unsigned thresh_ticks(input int unsigned spb,
                                               input int unsigned halves);
    return (spb * halves) / 2;
  endfunction

  // Exponent of two of the tick period in base-clock cycles.
  function automatic int unsigned tick_exp(input logic        rev_fix,
                                           input int unsigned pre,
                                           input int unsigned sel);
    return rev_fix ? pre : pre + sel;
  endfunction

endpackage

// File: rtl/lin_wk_cfg.sv
module lin_wk_cfg
  import lin_wk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic             lock_i,
  input  logic [CFG_W-1:0] wdata_i,
  output wk_cfg_t          cfg_o
);

  wk_cfg_t cfg_q;
  wk_cfg_t wr_val;
  logic    accept;

  assign wr_val = wk_cfg_t'(wdata_i);
  assign accept = we_i && !lock_i && spb_code_ok(wr_val.spb_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (accept) cfg_q <= wr_val;
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/lin_wk_sync.sv
module lin_wk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic rx_s_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= rx_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain[STAGES-1];
  end

  assign rx_s_o = chain[STAGES-1];
  assign fall_o = prev_q && !chain[STAGES-1];

endmodule

// File: rtl/lin_wk_timebase.sv
module lin_wk_timebase #(
  parameter int unsigned DIV_W = 10,
  parameter int unsigned EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;
  logic             at_end;

  always_comb begin
    for (int i = 0; i < int'(DIV_W); i++) mask[i] = (i < int'(exp_i));
  end

  assign at_end = (div_q == mask);
  assign tick_o = run_i && !restart_i && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  div_q <= '0;
    else if (restart_i || !run_i) div_q <= '0;
    else if (at_end)             div_q <= '0;
    else                         div_q <= div_q + 1'b1;
  end

endmodule

// File: rtl/lin_wk_meter.sv
module lin_wk_meter #(
  parameter int unsigned TH    = 40,
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic             rx_s_i,
  input  logic             fall_i,
  input  logic             tick_i,
  input  logic             clr_i,
  output logic             meas_o,
  output logic             evt_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wake_o
);

  logic             meas_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wake_q;
  logic             last_tick;

  assign last_tick = (cnt_q == CNT_W'(TH - 1));
  assign evt_o     = active_i && meas_q && !rx_s_i && !fall_i && tick_i && last_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meas_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!active_i) begin
      meas_q <= 1'b0;
      cnt_q  <= '0;
    end else if (fall_i) begin
      meas_q <= 1'b1;
      cnt_q  <= '0;
    end else if (meas_q && rx_s_i) begin
      meas_q <= 1'b0;
      cnt_q  <= '0;
    end else if (meas_q && tick_i) begin
      if (last_tick) begin
        meas_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 wake_q <= 1'b0;
    else if (evt_o)             wake_q <= 1'b1;
    else if (clr_i && rx_s_i)   wake_q <= 1'b0;
  end

  assign meas_o = meas_q;
  assign cnt_o  = cnt_q;
  assign wake_o = wake_q;

endmodule

// File: rtl/lin_wake_detect.sv
module lin_wake_detect
  import lin_wk_pkg::*;
#(
  parameter int unsigned SEL_W       = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SAMPLES     = 16,
  parameter int unsigned HALF_BITS   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd_i,
  input  logic             om_run_i,
  input  logic             wake_mode_i,
  input  logic [SEL_W-1:0] clk_sel_i,
  input  logic             cfg_we_i,
  input  logic [7:0]       cfg_wdata_i,
  output logic [7:0]       cfg_rdata_o,
  input  logic             wake_clr_i,
  output logic             wake_o
);

  localparam int unsigned TH_TICKS = thresh_ticks(SAMPLES, HALF_BITS);
  localparam int unsigned CNT_W    = $clog2(TH_TICKS + 1);
  localparam int unsigned MAX_EXP  = 7 + (2 ** SEL_W) - 1;
  localparam int unsigned EXP_W    = $clog2(MAX_EXP + 1);
  localparam int unsigned DIV_W    = MAX_EXP;

  wk_cfg_t          cfg;
  logic             rx_s;
  logic             rx_fall;
  logic             active;
  logic             meas;
  logic             tick;
  logic             wake_evt;
  logic [CNT_W-1:0] low_cnt;
  logic [EXP_W-1:0] tb_exp;

  assign active = om_run_i && wake_mode_i;
  assign tb_exp = EXP_W'(tick_exp(cfg.rev_fix, int'(cfg.pre_exp), int'(clk_sel_i)));

  lin_wk_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (cfg_we_i),
    .lock_i  (om_run_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  lin_wk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_i   (rxd_i),
    .rx_s_o (rx_s),
    .fall_o (rx_fall)
  );

  lin_wk_timebase #(.DIV_W(DIV_W), .EXP_W(EXP_W)) u_tb (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (rx_fall),
    .run_i     (meas && !rx_s),
    .exp_i     (tb_exp),
    .tick_o    (tick)
  );

  lin_wk_meter #(.TH(TH_TICKS), .CNT_W(CNT_W)) u_meter (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (active),
    .rx_s_i   (rx_s),
    .fall_i   (rx_fall),
    .tick_i   (tick),
    .clr_i    (wake_clr_i),
    .meas_o   (meas),
    .evt_o    (wake_evt),
    .cnt_o    (low_cnt),
    .wake_o   (wake_o)
  );

  assign cfg_rdata_o = cfg;

endmodule

// File: rtl/lin_wk_chk.sv
module lin_wk_chk #(
  parameter int unsigned TH    = 40,
  parameter int unsigned CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             om_run_i,
  input logic             cfg_we_i,
  input logic [7:0]       cfg_wdata_i,
  input logic [7:0]       cfg_rdata_o,
  input logic             wake_clr_i,
  input logic             wake_o,
  input logic             rx_s,
  input logic             wake_evt,
  input logic             active,
  input logic [CNT_W-1:0] low_cnt
);

  a_r2_locked_when_running: assert property (@(posedge clk) disable iff (!rst_n)
    om_run_i |=> $stable(cfg_rdata_o));

  a_r3_illegal_code_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && cfg_wdata_i[7:4] != 4'h0 && cfg_wdata_i[7:4] != 4'hF)
      |=> $stable(cfg_rdata_o));

  a_r6_count_below_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt < CNT_W'(TH));

  a_r6_event_only_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |-> !rx_s);

  a_r6_flag_rises_after_event: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_o) |-> $past(wake_evt));

  a_r7_no_event_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !wake_evt);

  a_r8_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_o && !(wake_clr_i && rx_s)) |=> wake_o);

  a_r8_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_o && wake_clr_i && rx_s && !wake_evt) |=> !wake_o);

endmodule

bind lin_wake_detect lin_wk_chk #(.TH(TH_TICKS), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .om_run_i    (om_run_i),
  .cfg_we_i    (cfg_we_i),
  .cfg_wdata_i (cfg_wdata_i),
  .cfg_rdata_o (cfg_rdata_o),
  .wake_clr_i  (wake_clr_i),
  .wake_o      (wake_o),
  .rx_s        (rx_s),
  .wake_evt    (wake_evt),
  .active      (active),
  .low_cnt     (low_cnt)
);

// File: tb/lin_wake_detect_tb.sv
module lin_wake_detect_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       om_run = 1'b0;
  logic       wmode = 1'b0;
  logic [1:0] sel = 2'd0;
  logic       we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       clr = 1'b0;
  logic       wake;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  lin_wake_detect u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .rxd_i       (rxd),
    .om_run_i    (om_run),
    .wake_mode_i (wmode),
    .clk_sel_i   (sel),
    .cfg_we_i    (we),
    .cfg_wdata_i (wdata),
    .cfg_rdata_o (rdata),
    .wake_clr_i  (clr),
    .wake_o      (wake)
  );

  // Tick period in base-clock cycles, restated from R4/R5.
  function automatic int period(input logic [7:0] c, input logic [1:0] s);
    int d;
    d = 1;
    repeat (int'(c[3:1])) d = d * 2;
    if (c[0] == 1'b0) repeat (int'(s)) d = d * 2;
    return d;
  endfunction

  function automatic bit expect_wake(input int low_len, input int d);
    return low_len > 40 * d;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk); we = 1'b1; wdata = v;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic low_pulse(input int len);
    @(negedge clk); rxd = 1'b0;
    repeat (len) @(negedge clk);
    rxd = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic clear_flag;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic enter_run;
    @(negedge clk); om_run = 1'b1; wmode = 1'b1;
  endtask

  task automatic enter_reset;
    @(negedge clk); om_run = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 cfg", rdata, 8'h00);
    check("R1 flag", wake, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: legal code accepted, illegal dropped
    write_cfg(8'hF5);
    check("R3 legal", rdata, 8'hF5);
    write_cfg(8'h53);
    check("R3 illegal kept", rdata, 8'hF5);
    write_cfg(8'h0C);
    check("R3 zero code", rdata, 8'h0C);

    // R2: write while running ignored
    enter_run;
    write_cfg(8'hF1);
    check("R2 locked", rdata, 8'h0C);
    enter_reset;

    // R5: revision bit forces undivided source: p=2, sel=3
    sel = 2'd3;
    write_cfg(8'h05);             // rev=1, p=2 -> D=4
    enter_run;
    low_pulse(162);
    check("R5 rev1 wake", wake, 1);
    clear_flag;
    check("R8 cleared", wake, 0);
    enter_reset;
    write_cfg(8'h04);             // rev=0, p=2, sel=3 -> D=32
    enter_run;
    low_pulse(162);
    check("R5 rev0 no wake", wake, 0);
    enter_reset;

    // R7: not in wake mode / reset mode
    write_cfg(8'h00);
    sel = 2'd0;
    @(negedge clk); om_run = 1'b1; wmode = 1'b0;
    low_pulse(100);
    check("R7 no wake mode", wake, 0);
    @(negedge clk); om_run = 1'b0; wmode = 1'b1;
    low_pulse(100);
    check("R7 reset mode", wake, 0);

    // R6: restart on each fall: two 30-tick pulses, D=1
    enter_run;
    @(negedge clk); rxd = 1'b0;
    repeat (30) @(negedge clk);
    rxd = 1'b1;
    repeat (3) @(negedge clk);
    rxd = 1'b0;
    repeat (30) @(negedge clk);
    rxd = 1'b1;
    repeat (6) @(negedge clk);
    check("R6 restart", wake, 0);

    // R8: clear while bus low ignored
    @(negedge clk); rxd = 1'b0;
    repeat (50) @(negedge clk);
    check("R6 long low", wake, 1);
    clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    @(negedge clk);
    check("R8 clr while low", wake, 1);
    rxd = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 held after release", wake, 1);
    clear_flag;
    check("R8 clear high", wake, 0);
    enter_reset;

    // R4/R5/R6: random configurations, above and below threshold
    for (int it = 0; it < 14; it++) begin
      logic [7:0] c;
      int d;
      int len;
      bit hit;
      c = {($urandom % 2) ? 4'hF : 4'h0, 3'($urandom % 4), 1'($urandom % 2)};
      sel = 2'($urandom % 4);
      write_cfg(c);
      check("R4 cfg", rdata, c);
      d = period(c, sel);
      hit = ($urandom % 2) == 1;
      if (hit) len = 40 * d + 2 + int'($urandom % (d + 3));
      else     len = 40 * d - 2 - int'($urandom % d);
      enter_run;
      low_pulse(len);
      check(hit ? "R6 above" : "R4 below", wake, int'(expect_wake(len, d)));
      clear_flag;
      check("R8 clear", wake, 0);
      enter_reset;
    end

    // R4: largest prescaler with forced base clock, D=128
    write_cfg(8'h0F);
    sel = 2'd3;
    enter_run;
    low_pulse(40 * 128 - 3);
    check("R4 p7 below", wake, 0);
    low_pulse(40 * 128 + 3);
    check("R4 p7 above", wake, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule